// File: doc/BRIEF.md
# Bouncing Sequence Counter with Descending Dwell

This block is a free-running sequence generator. After reset its output climbs one step per clock from the bottom value to the top value. It then walks back down one step per clock. On the way down, a single intermediate value is held for one extra clock. When the output reaches the bottom again, the climb restarts, and the pattern repeats with no outside control.

With the default parameters the output is 3 bits wide. It sweeps 0 through 7 upward and then 6,5,4,4,3,2,1 downward, which gives a period of 15 clocks. A one-bit status output tells the direction of travel. The only controls are the clock and a synchronous active-high reset. The top value, the bottom value and the dwell value are parameters.

Top module: `bounce_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next `count` is 0 (the bottom value) and `going_down` is 0.
- R2: When `going_down` is 0, each clock raises `count` by exactly 1. With defaults the rising leg is 0,1,2,3,4,5,6,7, and the value 4 is not repeated on this leg.
- R3: When `count` reaches 7 (the top value), `going_down` is 1 in that same cycle, and the next `count` is 6.
- R4: When `going_down` is 1 and `count` is not the dwell value 4, each clock lowers `count` by exactly 1.
- R5: On the falling leg the value 4 is output on exactly two consecutive cycles, and then 3 follows.
- R6: When `count` returns to 0, `going_down` is 0 in that cycle, and the next `count` is 1.
- R7: With no reset applied, the output sequence repeats with a period of 15 clocks: 0,1,2,3,4,5,6,7,6,5,4,4,3,2,1.
- R8: A reset at any point in the sequence restarts it from 0 on the rising leg, and the next descent again dwells at 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| count | output | W (3) | Current sequence value |
| going_down | output | 1 | 1 while on the falling leg (from the top value until the bottom value is reached) |

## Verification
Every output is registered. A reset or a step applied at one rising edge is therefore visible after that edge and holds until the next one. The bench drives `rst` on falling edges, and at each later falling edge it compares `count` and `going_down` against a position-in-period model that advances once per rising edge. Because each comparison happens exactly one edge after the stimulus that caused it, the dwell at 4 is judged cycle by cycle, in the cycle where it must occur.

// File: rtl/bounce_seq.sv
module bounce_seq #(
  parameter int W    = 3,
  parameter int BOT  = 0,
  parameter int TOP  = 7,
  parameter int HOLD = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count,
  output logic         going_down
);
  localparam logic [W-1:0] BOT_V  = W'(BOT);
  localparam logic [W-1:0] TOP_V  = W'(TOP);
  localparam logic [W-1:0] HOLD_V = W'(HOLD);
  localparam logic [W-1:0] ONE    = W'(1);

  logic [W-1:0] cnt_q;
  logic         dn_q;
  logic         armed_q;

  wire at_top_next = (cnt_q + ONE) == TOP_V;
  wire at_bot_next = (cnt_q - ONE) == BOT_V;
  wire dwell_now   = dn_q && armed_q && (cnt_q == HOLD_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= BOT_V;
      dn_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (!dn_q) begin
      cnt_q <= cnt_q + ONE;
      if (at_top_next) begin
        dn_q    <= 1'b1;
        armed_q <= 1'b1;
      end
    end else if (dwell_now) begin
      armed_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - ONE;
      if (at_bot_next) dn_q <= 1'b0;
    end
  end

  assign count      = cnt_q;
  assign going_down = dn_q;
endmodule

module bounce_seq_chk #(
  parameter int W    = 3,
  parameter int BOT  = 0,
  parameter int TOP  = 7,
  parameter int HOLD = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] count,
  input logic         going_down
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (count == W'(BOT) && !going_down)); // R1
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    !going_down |=> count == W'($past(count) + W'(1))); // R2
  AST_TOP_TURN: assert property (@(posedge clk) disable iff (rst)
    (count == W'(TOP)) |-> going_down); // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (going_down && count != W'(HOLD)) |=> count == W'($past(count) - W'(1))); // R4
  AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (going_down && count == W'(HOLD) && $past(count) != W'(HOLD)) |=> count == W'(HOLD)); // R5
  AST_DWELL_LEAVE: assert property (@(posedge clk) disable iff (rst)
    (going_down && count == W'(HOLD) && $past(count) == W'(HOLD)) |=> count == W'(HOLD - 1)); // R5
  AST_BOT_TURN: assert property (@(posedge clk) disable iff (rst)
    (count == W'(BOT)) |-> !going_down); // R6
endmodule

bind bounce_seq bounce_seq_chk #(.W(W), .BOT(BOT), .TOP(TOP), .HOLD(HOLD)) u_chk (
  .clk(clk), .rst(rst), .count(count), .going_down(going_down)
);

// File: tb/tb_bounce_seq.sv
`timescale 1ns/1ps
module tb_bounce_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] count;
  logic       going_down;
  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit fresh = 1'b1;
  bit done = 1'b0;
  int ref_seq[15];

  always #2.5 clk = ~clk;

  bounce_seq dut (.clk(clk), .rst(rst), .count(count), .going_down(going_down));

  function automatic int exp_val(int p);
    if (p <= 7) return p;
    if (p <= 10) return 14 - p;
    return 15 - p;
  endfunction

  function automatic bit exp_dn(int p);
    return (p >= 7);
  endfunction

  function automatic string tag_of(int p, bit after_rst);
    if (p == 0) return after_rst ? "R1/R8" : "R6";
    if (p == 7) return "R3";
    if (p < 7) return "R2";
    if (p == 11 || p == 10) return "R5";
    return "R4";
  endfunction

  task automatic check_now();
    string t = tag_of(pos, fresh);
    checks++;
    if (int'(count) != exp_val(pos) || going_down != exp_dn(pos)) begin
      errors++;
      $display("FAIL %s pos=%0d count=%0d dn=%0b expected count=%0d dn=%0b",
               t, pos, count, going_down, exp_val(pos), exp_dn(pos));
    end
  endtask

  task automatic step(bit r);
    rst = r;
    @(negedge clk);
    if (r) begin pos = 0; fresh = 1'b1; end
    else begin pos = (pos + 1) % 15; fresh = 1'b0; end
    check_now();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(1'b1);
    // R1 reset state, then two full directed periods (R2..R6)
    for (int i = 0; i < 30; i++) step(1'b0);
    // R7: record one period, compare to the next one
    for (int i = 0; i < 15; i++) begin ref_seq[i] = int'(count); step(1'b0); end
    for (int i = 0; i < 15; i++) begin
      checks++;
      if (int'(count) != ref_seq[i]) begin
        errors++;
        $display("FAIL R7 offset=%0d count=%0d expected=%0d", i, count, ref_seq[i]);
      end
      step(1'b0);
    end
    // R8: directed resets just before and during the dwell, and at the top
    for (int i = 0; i < 10; i++) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 7; i++) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 11; i++) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 20; i++) step(1'b0);
    // constrained random resets (about 2 percent of cycles)
    for (int i = 0; i < 4000; i++) step($urandom_range(0, 99) < 2);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule